// File: doc/BRIEF.md
# Indivisible Byte Test-and-Set Bus Master

This block is a bus-master sequencer for an asynchronous, strobe-based 16-bit bus with separate strobes for the two byte lanes. On a start request it runs one locked byte read-modify-write at a single address. It presents a 23-bit word address, a byte-lane select and a 3-bit function code, and it reads the byte from the slave. It then writes the byte back with its top bit set and reports the value it found. The whole exchange sits inside one assertion of the address strobe. Another master watching that strobe therefore never sees a gap between the read and the write. This is what makes the exchange usable as a lock primitive between processors.

Between the two phases only the data strobe drops and rises again. Before each data strobe is raised, the master waits for the slave acknowledge to go inactive. If an expected acknowledge does not arrive within a parameterised number of cycles, the cycle is abandoned and an error pulse is raised.

Top module: `rmw_bus_master`

## Requirements
- R1: During and right after reset, the address strobe and both data strobes are inactive (high), the read/write line is high (read), and busy, done and error are low.
- R2: In the read phase, the read/write line is high, and the address and function code are valid when the data strobe falls. With an idle acknowledge, the address strobe falls exactly one cycle before the data strobe.
- R3: Lane select 1 uses the lower strobe and data bits 7..0. Lane select 0 uses the upper strobe and data bits 15..8. The unselected strobe never goes active.
- R4: When the acknowledge (active low) is seen during the read strobe, the selected byte is latched and the data strobe is released. The address strobe stays active without a break from the read data strobe until the write data strobe has been released.
- R5: In the write phase, the read/write line goes low one cycle before the data strobe falls. The selected lane carries the original byte with bit 7 forced to 1.
- R6: Termination is sequenced one cycle per step: the data strobe rises, the address strobe rises on the next cycle, the data bus is released, and the read/write line returns high two cycles after the address strobe rises.
- R7: Done is a single-cycle pulse in the cycle in which read/write has returned high. At that point the original byte, a zero flag (byte equals 0) and a negative flag (bit 7 of the byte) are valid.
- R8: A start request that arrives while a cycle is in progress is ignored. No second bus cycle follows.
- R9: If no acknowledge arrives within ACK_TIMEOUT cycles of a data strobe going active, all strobes are released, read/write is high, and error pulses for one cycle without done. The error falls ACK_TIMEOUT cycles after the strobe falls.
- R10: An acknowledge first seen in the last cycle of the timeout window completes the cycle normally. It takes precedence over the timeout.
- R11: A data strobe is not asserted while the acknowledge is still active from an earlier transfer. The master waits until the acknowledge is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a test-and-set cycle (sampled when idle) |
| addr_i | input | 23 | Word address |
| lane_lo_i | input | 1 | 1 selects the low byte lane, 0 the high lane |
| fc_i | input | 3 | Function code for the cycle |
| ack_n_i | input | 1 | Slave acknowledge, active low |
| addr_o | output | 23 | Address bus, high impedance when idle |
| fc_o | output | 3 | Function code bus, high impedance when idle |
| as_n_o | output | 1 | Address strobe, active low |
| uds_n_o | output | 1 | Upper byte data strobe, active low |
| lds_n_o | output | 1 | Lower byte data strobe, active low |
| rw_o | output | 1 | 1 = read, 0 = write |
| data_io | inout | 16 | Bidirectional data bus |
| busy_o | output | 1 | A cycle is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle acknowledge timeout pulse |
| orig_o | output | 8 | Byte read from the slave |
| zero_o | output | 1 | Original byte was zero |
| neg_o | output | 1 | Bit 7 of the original byte |

## Verification
An acknowledge and the expiry of the timeout can land in the same cycle. This happens when the slave answers in the final cycle of the wait window. The stimulus table includes a slave delay of exactly ACK_TIMEOUT-1 cycles after the data strobe falls. That transfer must finish with done, the correct written byte and no error pulse. A second case uses a delay of ACK_TIMEOUT and must produce an error exactly ACK_TIMEOUT cycles after the strobe fell, with no done. A start request that arrives during a busy cycle is a second kind of collision. It is judged by watching that the bus stays idle after the single done pulse.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [3:0] {
    S_IDLE    = 4'd0,
    S_RD_ADDR = 4'd1,
    S_RD_AS   = 4'd2,
    S_RD_DS   = 4'd3,
    S_MODIFY  = 4'd4,
    S_WR_DATA = 4'd5,
    S_WR_DS   = 4'd6,
    S_DS_OFF  = 4'd7,
    S_AS_OFF  = 4'd8,
    S_REL     = 4'd9,
    S_DONE    = 4'd10,
    S_ERR     = 4'd11
  } rmw_state_e;

  localparam int unsigned ADDR_W = 23;
  localparam int unsigned FC_W   = 3;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = 2;
  localparam int unsigned DATA_W = BYTE_W * LANES;

endpackage

// File: rtl/rmw_ack_timer.sv
module rmw_ack_timer #(
  parameter int unsigned ACK_TIMEOUT = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clr_i,
  output logic expire_o
);
  localparam int unsigned CW = (ACK_TIMEOUT < 2) ? 1 : $clog2(ACK_TIMEOUT);
  localparam logic [CW-1:0] LAST = CW'(ACK_TIMEOUT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expire_o = run_i && (cnt_q == LAST);
  assign cnt_en   = clr_i || (run_i && !expire_o);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)
      cnt_d = '0;
    else if (run_i && !expire_o)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  // R9: the wait counter never passes the last cycle of the window
  assert_cnt_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R9: a window restarts from zero after a clear
  assert_clear_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/rmw_modify.sv
module rmw_modify
  import rmw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              lane_lo_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [BYTE_W-1:0] orig_o,
  output logic [BYTE_W-1:0] wr_byte_o,
  output logic              zero_o,
  output logic              neg_o
);
  logic [BYTE_W-1:0] lane_byte;
  logic [BYTE_W-1:0] orig_q;

  assign lane_byte = lane_lo_i ? bus_i[BYTE_W-1:0] : bus_i[DATA_W-1:BYTE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      orig_q <= '0;
    else if (load_i)
      orig_q <= lane_byte;
  end

  assign orig_o    = orig_q;
  assign zero_o    = (orig_q == '0);
  assign neg_o     = orig_q[BYTE_W-1];
  assign wr_byte_o = {1'b1, orig_q[BYTE_W-2:0]};

  // R4: the byte captured is the one on the selected lane at the acknowledge
  assert_latch_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (orig_o == ($past(lane_lo_i) ? $past(bus_i[BYTE_W-1:0])
                                            : $past(bus_i[DATA_W-1:BYTE_W]))));

endmodule

// File: rtl/rmw_sequencer.sv
module rmw_sequencer
  import rmw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              lane_lo_i,
  input  logic [FC_W-1:0]   fc_i,
  input  logic              ack_n_i,
  input  logic              expire_i,
  output logic              tmr_run_o,
  output logic              tmr_clr_o,
  output logic              latch_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [FC_W-1:0]   fc_o,
  output logic              lane_lo_o,
  output logic              addr_en_o,
  output logic              as_n_o,
  output logic              ds_n_o,
  output logic              rw_o,
  output logic              drive_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  rmw_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [FC_W-1:0]   fc_q;
  logic              lane_q;
  logic              req_en;

  assign req_en = (state_q == S_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    latch_o = 1'b0;
    unique case (state_q)
      S_IDLE:    if (start_i) state_d = S_RD_ADDR;
      S_RD_ADDR: state_d = S_RD_AS;
      S_RD_AS: begin
        if (ack_n_i)       state_d = S_RD_DS;
        else if (expire_i) state_d = S_ERR;
      end
      S_RD_DS: begin
        if (!ack_n_i) begin
          latch_o = 1'b1;
          state_d = S_MODIFY;
        end else if (expire_i) begin
          state_d = S_ERR;
        end
      end
      S_MODIFY: begin
        if (ack_n_i)       state_d = S_WR_DATA;
        else if (expire_i) state_d = S_ERR;
      end
      S_WR_DATA: state_d = S_WR_DS;
      S_WR_DS: begin
        if (!ack_n_i)      state_d = S_DS_OFF;
        else if (expire_i) state_d = S_ERR;
      end
      S_DS_OFF: state_d = S_AS_OFF;
      S_AS_OFF: state_d = S_REL;
      S_REL:    state_d = S_DONE;
      S_DONE:   state_d = S_IDLE;
      S_ERR:    state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= S_IDLE;
    else
      state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      fc_q   <= '0;
      lane_q <= 1'b0;
    end else if (req_en) begin
      addr_q <= addr_i;
      fc_q   <= fc_i;
      lane_q <= lane_lo_i;
    end
  end

  always_comb begin
    as_n_o    = 1'b1;
    ds_n_o    = 1'b1;
    rw_o      = 1'b1;
    drive_o   = 1'b0;
    addr_en_o = 1'b0;
    tmr_run_o = 1'b0;
    unique case (state_q)
      S_RD_ADDR: addr_en_o = 1'b1;
      S_RD_AS:   begin addr_en_o = 1'b1; as_n_o = 1'b0; tmr_run_o = 1'b1; end
      S_RD_DS:   begin addr_en_o = 1'b1; as_n_o = 1'b0; ds_n_o = 1'b0; tmr_run_o = 1'b1; end
      S_MODIFY:  begin addr_en_o = 1'b1; as_n_o = 1'b0; tmr_run_o = 1'b1; end
      S_WR_DATA: begin addr_en_o = 1'b1; as_n_o = 1'b0; rw_o = 1'b0; drive_o = 1'b1; end
      S_WR_DS:   begin addr_en_o = 1'b1; as_n_o = 1'b0; ds_n_o = 1'b0; rw_o = 1'b0;
                       drive_o = 1'b1; tmr_run_o = 1'b1; end
      S_DS_OFF:  begin addr_en_o = 1'b1; as_n_o = 1'b0; rw_o = 1'b0; drive_o = 1'b1; end
      S_AS_OFF:  begin rw_o = 1'b0; drive_o = 1'b1; end
      S_REL:     rw_o = 1'b0;
      default:   ;
    endcase
  end

  assign tmr_clr_o = (state_d != state_q);
  assign addr_o    = addr_q;
  assign fc_o      = fc_q;
  assign lane_lo_o = lane_q;
  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = (state_q == S_DONE);
  assign err_o     = (state_q == S_ERR);

  // R4: leaving the read strobe toward the modify step keeps the address strobe low
  assert_as_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q == S_RD_DS) && state_q == S_MODIFY) |-> !as_n_o);

  // R7: completion lasts exactly one cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: an error pulse lasts one cycle and leaves the bus idle
  assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (as_n_o && ds_n_o && rw_o && !drive_o && !done_o));

  // R8: the captured request cannot change while a cycle runs
  assert_req_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_o) && busy_o) |-> ($stable(addr_q) && $stable(fc_q) && $stable(lane_q)));

  // R11: a data strobe only begins after an inactive acknowledge was seen
  assert_ack_idle_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ds_n_o) |-> $past(ack_n_i));

endmodule

// File: rtl/rmw_bus_master.sv
module rmw_bus_master
  import rmw_pkg::*;
#(
  parameter int unsigned ACK_TIMEOUT = 255
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [22:0] addr_i,
  input  logic        lane_lo_i,
  input  logic [2:0]  fc_i,
  input  logic        ack_n_i,
  output logic [22:0] addr_o,
  output logic [2:0]  fc_o,
  output logic        as_n_o,
  output logic        uds_n_o,
  output logic        lds_n_o,
  output logic        rw_o,
  inout  wire  [15:0] data_io,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic [7:0]  orig_o,
  output logic        zero_o,
  output logic        neg_o
);
  logic              tmr_run, tmr_clr, expire, latch;
  logic [ADDR_W-1:0] seq_addr;
  logic [FC_W-1:0]   seq_fc;
  logic              lane_lo, addr_en, ds_n, drive;
  logic [BYTE_W-1:0] wr_byte;

  rmw_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .addr_i    (addr_i),
    .lane_lo_i (lane_lo_i),
    .fc_i      (fc_i),
    .ack_n_i   (ack_n_i),
    .expire_i  (expire),
    .tmr_run_o (tmr_run),
    .tmr_clr_o (tmr_clr),
    .latch_o   (latch),
    .addr_o    (seq_addr),
    .fc_o      (seq_fc),
    .lane_lo_o (lane_lo),
    .addr_en_o (addr_en),
    .as_n_o    (as_n_o),
    .ds_n_o    (ds_n),
    .rw_o      (rw_o),
    .drive_o   (drive),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o)
  );

  rmw_ack_timer #(.ACK_TIMEOUT(ACK_TIMEOUT)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (tmr_run),
    .clr_i    (tmr_clr),
    .expire_o (expire)
  );

  rmw_modify u_mod (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (latch),
    .lane_lo_i (lane_lo),
    .bus_i     (data_io),
    .orig_o    (orig_o),
    .wr_byte_o (wr_byte),
    .zero_o    (zero_o),
    .neg_o     (neg_o)
  );

  assign addr_o  = addr_en ? seq_addr : 'z;
  assign fc_o    = addr_en ? seq_fc   : 'z;
  assign lds_n_o = ds_n | ~lane_lo;
  assign uds_n_o = ds_n | lane_lo;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam bit IS_LO = (g == 0);
    assign data_io[g*BYTE_W +: BYTE_W] = (drive && (lane_lo == IS_LO)) ? wr_byte : 'z;
  end

  // R3: the two byte strobes are never active together
  assert_one_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!uds_n_o && !lds_n_o));

  // R4: any active data strobe lies inside an active address strobe
  assert_ds_in_as_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!uds_n_o || !lds_n_o) |-> !as_n_o);

  // R5: direction does not change under an active data strobe
  assert_rw_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!uds_n_o || !lds_n_o) |-> $stable(rw_o));

  // R6: the address strobe rises only one cycle after a data strobe release
  assert_as_after_ds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(as_n_o) && !err_o) |-> ($past(uds_n_o) && $past(lds_n_o)));

endmodule

// File: tb/rmw_bus_master_bench.sv
module rmw_bus_master_bench;
  localparam int TMO = 8;

  logic        clk, rst_n, start, lane_lo, ack_n;
  logic [22:0] addr;
  logic [2:0]  fc;
  wire  [22:0] addr_o;
  wire  [2:0]  fc_o;
  logic        as_n, uds_n, lds_n, rw, busy, done, err, zero, neg;
  logic [7:0]  orig;
  wire  [15:0] data_io;
  logic [15:0] slv_data;
  logic        slv_drv;
  int          checks, errors;

  assign data_io = slv_drv ? slv_data : 16'hzzzz;

  rmw_bus_master #(.ACK_TIMEOUT(TMO)) u_rmw_bus_master (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .lane_lo_i(lane_lo),
    .fc_i(fc), .ack_n_i(ack_n), .addr_o(addr_o), .fc_o(fc_o), .as_n_o(as_n),
    .uds_n_o(uds_n), .lds_n_o(lds_n), .rw_o(rw), .data_io(data_io), .busy_o(busy),
    .done_o(done), .err_o(err), .orig_o(orig), .zero_o(zero), .neg_o(neg));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {addr, lane_lo, fc, slave byte, ack delay}
  localparam logic [38:0] VECS [0:5] = '{
    {23'h000123, 1'b1, 3'd5, 8'h00, 4'd0},
    {23'h7FFFFF, 1'b0, 3'd1, 8'h80, 4'd1},
    {23'h2AAAAA, 1'b1, 3'd2, 8'h7F, 4'd3},
    {23'h155555, 1'b0, 3'd6, 8'hC3, 4'd2},
    {23'h000001, 1'b0, 3'd5, 8'h01, 4'd7},
    {23'h400000, 1'b1, 3'd0, 8'hFF, 4'd7}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic [22:0] a, input logic lo, input logic [2:0] f,
                         input logic [7:0] mem, input int dly, input int pre_ack,
                         input bit poke, input bit exp_err);
    int as_fall = -1, rd_fall = -1, rw_fall = -1, wr_fall = -1, wr_rise = -1;
    int as_rise = -1, rw_rise = -1, done_c = -1, err_c = -1, ack_cnt = 0;
    bit p_as = 1, p_ds = 1, p_rw = 1, gap = 0, lane_bad = 0, r11_bad = 0;
    logic [7:0] wbyte = 8'h00;
    logic ds, other;
    @(negedge clk);
    start = 1'b1; addr = a; lane_lo = lo; fc = f;
    if (pre_ack > 0) ack_n = 1'b0;
    for (int cyc = 1; cyc < 100 && done_c < 0 && err_c < 0; cyc++) begin
      @(negedge clk);
      start = 1'b0;
      ds    = lo ? lds_n : uds_n;
      other = lo ? uds_n : lds_n;
      if (!other) lane_bad = 1;
      if (pre_ack > 0 && cyc <= pre_ack && !ds) r11_bad = 1;
      if (p_as && !as_n) as_fall = cyc;
      if (!p_as && as_n) as_rise = cyc;
      if (p_rw && !rw) rw_fall = cyc;
      if (!p_rw && rw) rw_rise = cyc;
      if (p_ds && !ds) begin
        if (rw) begin
          rd_fall = cyc;
          chk(addr_o == a, "R2 address at read strobe", int'(addr_o), int'(a));
          chk(fc_o == f, "R2 function code at read strobe", int'(fc_o), int'(f));
        end else begin
          wr_fall = cyc;
          wbyte = lo ? data_io[7:0] : data_io[15:8];
        end
      end
      if (!p_ds && ds && !rw) wr_rise = cyc;
      if (rd_fall >= 0 && wr_rise < 0 && as_n && !err) gap = 1;
      if (done) done_c = cyc;
      if (err) begin
        err_c = cyc;
        chk(as_n && uds_n && lds_n && rw, "R9 bus idle at error", {as_n, uds_n, lds_n, rw}, 4'hF);
      end
      if (poke && cyc == 5) begin start = 1'b1; addr = ~a; lane_lo = ~lo; end
      if (!ds && ack_n) begin
        if (ack_cnt == dly) begin
          ack_n = 1'b0;
          if (rw) begin slv_data = lo ? {~mem, mem} : {mem, ~mem}; slv_drv = 1'b1; end
        end else ack_cnt++;
      end
      if (ds && !ack_n && cyc >= pre_ack) begin ack_n = 1'b1; slv_drv = 1'b0; ack_cnt = 0; end
      p_as = as_n; p_ds = ds; p_rw = rw;
    end
    start = 1'b0;
    chk(!lane_bad, "R3 unselected strobe stayed inactive", lane_bad, 0);
    if (exp_err) begin
      chk(err_c >= 0 && done_c < 0, "R9 error without done", err_c, 1);
      chk(err_c == rd_fall + TMO, "R9 error timing", err_c - rd_fall, TMO);
    end else begin
      chk(done_c >= 0 && err_c < 0, "R10 done without error", done_c, 1);
      if (pre_ack == 0) chk(rd_fall == as_fall + 1, "R2 strobe order", rd_fall - as_fall, 1);
      else chk(!r11_bad && rd_fall == pre_ack + 1, "R11 strobe waits for idle ack", rd_fall, pre_ack + 1);
      chk(!gap, "R4 address strobe held across phases", gap, 0);
      chk(wr_fall == rw_fall + 1, "R5 write strobe after rw low", wr_fall - rw_fall, 1);
      chk(wbyte == (mem | 8'h80), "R5 written byte", wbyte, mem | 8'h80);
      chk(as_rise == wr_rise + 1, "R6 as after ds", as_rise - wr_rise, 1);
      chk(rw_rise == as_rise + 2, "R6 rw after release", rw_rise - as_rise, 2);
      chk(done_c == rw_rise, "R7 done with rw high", done_c, rw_rise);
      chk(orig == mem && zero == (mem == 0) && neg == mem[7], "R7 reported byte and flags",
          {orig, zero, neg}, {mem, mem == 8'h00, mem[7]});
    end
    @(negedge clk);
    chk(!done && !err, "R7 pulse is one cycle", {done, err}, 0);
    if (poke) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(as_n && !busy, "R8 ignored start started nothing", {as_n, busy}, 2);
      end
    end
  endtask

  initial begin
    int n = 0;
    while (n < 20000) begin @(posedge clk); n++; end
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; start = 1'b0; addr = '0; lane_lo = 1'b0; fc = '0;
    ack_n = 1'b1; slv_drv = 1'b0; slv_data = '0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(as_n && uds_n && lds_n && rw && !busy && !done && !err, "R1 reset state",
        {as_n, uds_n, lds_n, rw, busy, done, err}, 7'b1111000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(as_n && uds_n && lds_n && rw && !busy, "R1 after release", {as_n, uds_n, lds_n, rw, busy}, 5'b11110);

    for (int i = 0; i < 6; i++) begin
      logic [38:0] v;
      v = VECS[i];
      run_txn(v[38:16], v[15], v[14:12], v[11:4], int'(v[3:0]), 0, 1'b0, 1'b0);
    end

    // R11 acknowledge still active at start
    run_txn(23'h0ABCDE, 1'b1, 3'd5, 8'h5A, 0, 4, 1'b0, 1'b0);
    // R8 start during a busy cycle
    run_txn(23'h012345, 1'b0, 3'd1, 8'h10, 1, 0, 1'b1, 1'b0);
    // R9 acknowledge one cycle too late
    run_txn(23'h033333, 1'b1, 3'd5, 8'h22, TMO, 0, 1'b0, 1'b1);
    // R10 last window cycle after a timeout
    run_txn(23'h044444, 1'b0, 3'd2, 8'h00, TMO - 1, 0, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule